// File: doc/BRIEF.md
# Local Interrupt Count-Down Timer

This block is a per-core interrupt timer. Software programs a control entry that picks the timer mode and the interrupt vector, a clock divider, and either a count-down start value or an absolute deadline against a free-running 64-bit timestamp. When the count expires, or when the timestamp reaches the deadline, the block raises an interrupt request. The request carries the programmed vector and stays high until the core acknowledges it.

There are three modes. One-shot counts down once and then rests at zero. Periodic reloads from the start value each time the count expires. Deadline compares the timestamp input with a stored deadline. Rewriting the mode never disturbs the running count. A periodic reload only happens when the count steps from one to zero. As a result, switching modes has well-defined effects mid-count and after expiry.

Top module: `lvt_countdown_timer`

## Requirements
- R1: Register addresses: 0 control entry, 1 divider, 2 start count, 3 running count (read only), 4 deadline. In the control entry, bits 7:0 hold the vector, bit 16 is the mask and bits 18:17 are the mode (00 one-shot, 01 periodic, 10 deadline). `irq_vector` always shows the programmed vector.
- R2: The divider code {bit3, bit1, bit0} selects 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128, 111→1. For example, value 0xB divides by 1. The count steps once every D clocks, and writing the divider restarts the prescale phase.
- R3: A start-count write of N≠0 on clock edge E loads the running count and starts it. Expiry sets the request at edge E+N·D.
- R4: In one-shot mode the timer raises exactly one request per start, and the running count then stays at zero.
- R5: In periodic mode, expiry reloads the running count from the start value. Requests then repeat every N·D clocks.
- R6: Writing the control entry leaves the start value and the running count unchanged, and counting continues from where it was.
- R7: If the running count is already zero, switching from one-shot to periodic keeps it at zero and raises no request.
- R8: Writing a start count of zero stops the timer and raises no request.
- R9: In deadline mode, a non-zero deadline that is at or below the timestamp at edge E+1 sets the request at that edge. A deadline T+k written at edge E, where the timestamp is T at E, sets the request at edge E+k. After firing, the deadline register reads zero. Writing zero disarms the deadline.
- R10: The request holds until `irq_ack` clears it. An expiry while the mask bit is set raises no request.
- R11: After reset, every register reads zero and the request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| timestamp | input | 64 | Free-running time reference |
| irq_ack | input | 1 | Clears the pending request |
| irq_req | output | 1 | Pending interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The embedded assertions check the following on every cycle: a zero count never leaves zero except through a load, a periodic expiry reloads the start value, a control-entry write keeps the start value, a fired deadline clears itself, and the request holds until acknowledged. Only the bench scenarios can show the exact expiry time for every divider code and several start counts, the periodic spacing, a count that keeps running across a mode switch, and the absence of any request after a zero start, a mask, or a switch to periodic at zero. Deadlines in the past, at the present and in the future are measured against the timestamp.

// File: rtl/lct_pkg.sv
// Shared definitions for the count-down timer: register addresses, mode codes
// and the divider decode. Assumes a 3-bit register address space.
package lct_pkg;
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_DIV   = 3'd1;
    localparam logic [2:0] A_START = 3'd2;
    localparam logic [2:0] A_RUN   = 3'd3;
    localparam logic [2:0] A_DLINE = 3'd4;

    localparam logic [1:0] M_ONESHOT  = 2'b00;
    localparam logic [1:0] M_PERIODIC = 2'b01;
    localparam logic [1:0] M_DEADLINE = 2'b10;

    // Maps the divider code to log2 of the division ratio; code 7 means divide by 1.
    function automatic logic [2:0] div_shift(input logic [3:0] cfg);
        logic [2:0] sel;
        sel = {cfg[3], cfg[1:0]};
        return (sel == 3'd7) ? 3'd0 : sel + 3'd1;
    endfunction
endpackage

// File: rtl/lct_prescaler.sv
// Clock prescaler: emits one tick every 2^shift clocks.
// Assumes shift <= LOG2_MAX. A restart puts the phase back to zero.
module lct_prescaler #(
    parameter int LOG2_MAX = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] shift,
    output logic       tick
);
    localparam int PW = LOG2_MAX + 1;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] limit;

    // Terminal phase value for the selected ratio.
    always_comb limit = (PW'(1) << shift) - PW'(1);

    assign tick = (phase_q == limit) && !restart;

    // Phase counter, wrapping at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) phase_q <= '0;
        else                           phase_q <= phase_q + PW'(1);
    end

    a_r2_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= limit |=> (phase_q <= $past(limit)) || $past(restart) || (shift != $past(shift)));
endmodule

// File: rtl/lct_counter.sv
// Running count: loads on a start write, steps down on prescaler ticks while
// enabled, and on the step from one either reloads (periodic) or rests at zero.
// Assumes load and step never need to act in the same cycle (load wins).
module lct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             run,
    input  logic             periodic,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    assign expire = !load && run && tick && (cnt_q == ONE);
    assign count  = cnt_q;

    // Load, step down, reload or rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (load)                        cnt_q <= load_val;
        else if (expire)                      cnt_q <= periodic ? reload_val : '0;
        else if (run && tick && cnt_q != '0)  cnt_q <= cnt_q - ONE;
    end

    a_r7_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) && !load |=> cnt_q == '0);
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire && periodic |=> cnt_q == $past(reload_val));
    a_r4_oneshot_rest: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !periodic |=> cnt_q == '0);
endmodule

// File: rtl/lct_deadline.sv
// Deadline compare: holds an absolute deadline and fires once when enabled and
// the timestamp has reached it, then clears itself. Zero means disarmed.
module lct_deadline #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [TS_W-1:0] wdata,
    input  logic            en,
    input  logic [TS_W-1:0] ts,
    output logic [TS_W-1:0] dline,
    output logic            fire
);
    logic [TS_W-1:0] dl_q;

    assign fire  = en && !wr && (dl_q != '0) && (ts >= dl_q);
    assign dline = dl_q;

    // Deadline register: written by software, cleared when it fires.
    always_ff @(posedge clk) begin
        if (!rst_n)    dl_q <= '0;
        else if (wr)   dl_q <= wdata;
        else if (fire) dl_q <= '0;
    end

    a_r9_clear_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> dl_q == '0);
endmodule

// File: rtl/lvt_countdown_timer.sv
// Top of the count-down interrupt timer: register file, mode decode, pending
// request. Assumes a single-cycle write strobe and combinational reads.
module lvt_countdown_timer #(
    parameter int CNT_W    = 32,
    parameter int TS_W     = 64,
    parameter int VEC_W    = 8,
    parameter int LOG2_MAX = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [TS_W-1:0] reg_wdata,
    output logic [TS_W-1:0] reg_rdata,
    input  logic [TS_W-1:0] timestamp,
    input  logic            irq_ack,
    output logic            irq_req,
    output logic [VEC_W-1:0] irq_vector
);
    import lct_pkg::*;

    localparam int MASK_BIT = 16;
    localparam int MODE_LSB = 17;

    logic [VEC_W-1:0] vec_q;
    logic             mask_q;
    logic [1:0]       mode_q;
    logic [3:0]       div_q;
    logic [CNT_W-1:0] start_q;
    logic             pend_q;

    logic             wr_ctrl, wr_div, wr_start, wr_dl;
    logic             tick, expire, dl_fire, fire;
    logic [CNT_W-1:0] run_cnt;
    logic [TS_W-1:0]  dl_val;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_div   = reg_wr && (reg_addr == A_DIV);
    assign wr_start = reg_wr && (reg_addr == A_START);
    assign wr_dl    = reg_wr && (reg_addr == A_DLINE);

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            mask_q  <= 1'b0;
            mode_q  <= M_ONESHOT;
            div_q   <= '0;
            start_q <= '0;
        end else begin
            if (wr_ctrl) begin
                vec_q  <= reg_wdata[VEC_W-1:0];
                mask_q <= reg_wdata[MASK_BIT];
                mode_q <= reg_wdata[MODE_LSB+1:MODE_LSB];
            end
            if (wr_div)   div_q   <= reg_wdata[3:0];
            if (wr_start) start_q <= reg_wdata[CNT_W-1:0];
        end
    end

    lct_prescaler #(.LOG2_MAX(LOG2_MAX)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(wr_start || wr_div),
        .shift(div_shift(div_q)), .tick(tick)
    );

    lct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(wr_start),
        .load_val(reg_wdata[CNT_W-1:0]), .reload_val(start_q),
        .run(mode_q != M_DEADLINE), .periodic(mode_q == M_PERIODIC),
        .tick(tick), .count(run_cnt), .expire(expire)
    );

    lct_deadline #(.TS_W(TS_W)) u_dl (
        .clk(clk), .rst_n(rst_n), .wr(wr_dl), .wdata(reg_wdata),
        .en(mode_q == M_DEADLINE), .ts(timestamp), .dline(dl_val), .fire(dl_fire)
    );

    assign fire = (expire || dl_fire) && !mask_q;

    // Pending request: set by an unmasked event, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (fire)    pend_q <= 1'b1;
        else if (irq_ack) pend_q <= 1'b0;
    end

    assign irq_req    = pend_q;
    assign irq_vector = vec_q;

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[VEC_W-1:0]             = vec_q;
                reg_rdata[MASK_BIT]              = mask_q;
                reg_rdata[MODE_LSB+1:MODE_LSB]   = mode_q;
            end
            A_DIV:   reg_rdata[3:0]       = div_q;
            A_START: reg_rdata[CNT_W-1:0] = start_q;
            A_RUN:   reg_rdata[CNT_W-1:0] = run_cnt;
            A_DLINE: reg_rdata            = dl_val;
            default: reg_rdata = '0;
        endcase
    end

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && !fire |=> !irq_req);
    a_r10_holds: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req);
    a_r6_ctrl_keeps_start: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> $stable(start_q));
    a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req && mask_q && !wr_ctrl |=> !irq_req);
endmodule

// File: tb/lvt_countdown_timer_tb_top.sv
module lvt_countdown_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [63:0] ts = 64'd1000;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int total = 0;
    int bad = 0;
    int ncyc = 0;

    always #10 clk = ~clk;

    lvt_countdown_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timestamp(ts),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    initial forever begin
        @(posedge clk);
        ncyc++;
    end

    initial forever begin
        @(negedge clk);
        ts = ts + 64'd1;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic wr_dl_rel(input longint off);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = ts + 64'(off);
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic wait_irq(input int max, output int c);
        c = 0;
        while (!irq_req && c < max) begin
            @(negedge clk); #1;
            c++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic ack;
        @(negedge clk); #1; irq_ack = 1'b1;
        @(negedge clk); #1; irq_ack = 1'b0;
        check(!irq_req, "R10 ack clears", irq_req, 0);
    endtask

    function automatic logic [63:0] ctrl(input logic [1:0] m, input bit msk, input logic [7:0] v);
        return (64'(m) << 17) | (64'(msk) << 16) | 64'(v);
    endfunction

    initial begin
        logic [63:0] d;
        int c, seen, t1, t2, e0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R11 reset state
        check(!irq_req, "R11 req low", irq_req, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check(d == 0, "R11 register zero", d, 0);
        end

        // R1 R2 R3 R4: one-shot sweep over every divider code and small counts
        wr(3'd0, ctrl(2'b00, 1'b0, 8'h40));
        for (int sel = 0; sel < 8; sel++) begin
            int dv;
            dv = (sel == 7) ? 1 : (2 << sel);
            for (int n = 1; n <= 3; n++) begin
                wr(3'd1, {60'd0, sel[2], 1'b0, sel[1:0]});
                wr(3'd2, 64'(n));
                wait_irq(1000, c);
                check(c == n * dv, "R2 R3 expiry time", c, n * dv);
                check(irq_vector == 8'h40, "R1 vector", irq_vector, 8'h40);
                idle(3);
                check(irq_req, "R10 request held", irq_req, 1);
                ack();
                rd(3'd3, d);
                check(d == 0, "R4 count at zero", d, 0);
                wait_irq(20, c);
                check(!irq_req, "R4 single request", irq_req, 0);
            end
        end

        // R5 periodic spacing, divide by 2, start 3
        wr(3'd0, ctrl(2'b01, 1'b0, 8'h41));
        wr(3'd1, 64'h0);
        wr(3'd2, 64'd3);
        wait_irq(100, c);
        check(c == 6, "R5 first period", c, 6);
        t1 = ncyc;
        ack();
        wait_irq(100, c);
        t2 = ncyc;
        check(t2 - t1 == 6, "R5 period", t2 - t1, 6);
        ack();
        wait_irq(100, c);
        t1 = ncyc;
        check(t1 - t2 == 6, "R5 repeat period", t1 - t2, 6);

        // R6: mode switch mid-count keeps start value and running count
        wr(3'd1, 64'hB);
        wr(3'd2, 64'd20);
        e0 = ncyc;
        idle(4);
        wr(3'd0, ctrl(2'b00, 1'b0, 8'h42));
        rd(3'd2, d);
        check(d == 20, "R6 start kept", d, 20);
        rd(3'd3, d);
        check(d == 64'(20 - (ncyc - e0)), "R6 count continues", d, 20 - (ncyc - e0));
        ack();
        wait_irq(100, c);
        check(ncyc - e0 == 20, "R6 expiry unchanged", ncyc - e0, 20);
        ack();
        // R7: count zero, switch to periodic
        wr(3'd0, ctrl(2'b01, 1'b0, 8'h42));
        wait_irq(40, c);
        check(!irq_req, "R7 no request", irq_req, 0);
        rd(3'd3, d);
        check(d == 0, "R7 count stays zero", d, 0);

        // R8: start of zero stops the timer
        wr(3'd0, ctrl(2'b00, 1'b0, 8'h43));
        wr(3'd2, 64'd50);
        idle(5);
        wr(3'd2, 64'd0);
        wait_irq(80, c);
        check(!irq_req, "R8 no request", irq_req, 0);
        rd(3'd3, d);
        check(d == 0, "R8 count zero", d, 0);

        // R10: masked expiry raises nothing
        wr(3'd0, ctrl(2'b00, 1'b1, 8'h44));
        wr(3'd2, 64'd4);
        wait_irq(20, c);
        check(!irq_req, "R10 mask", irq_req, 0);

        // R9: deadline in the past, at present, in the future, and disarm
        wr(3'd0, ctrl(2'b10, 1'b0, 8'h77));
        wr_dl_rel(-5);
        wait_irq(50, c);
        check(c == 1, "R9 past deadline", c, 1);
        check(irq_vector == 8'h77, "R1 vector deadline", irq_vector, 8'h77);
        rd(3'd4, d);
        check(d == 0, "R9 deadline cleared", d, 0);
        ack();
        wr_dl_rel(0);
        wait_irq(50, c);
        check(c == 1, "R9 present deadline", c, 1);
        ack();
        wr_dl_rel(10);
        wait_irq(50, c);
        check(c == 10, "R9 future deadline", c, 10);
        rd(3'd4, d);
        check(d == 0, "R9 deadline cleared future", d, 0);
        ack();
        wr(3'd4, 64'd0);
        wait_irq(20, c);
        check(!irq_req, "R9 zero disarms", irq_req, 0);

        seen = 0;
        $display("  test done: total=%0d bad=%0d", total, bad + seen);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule